// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer and Read Port

This block is the digital control logic of an 8-bit sampling converter with up to eight multiplexed inputs. An active-low start line begins a conversion on its falling edge. The block freezes the sample of the selected channel, times the conversion in clock cycles and reports completion with a short active-low done pulse. The analog values come in as one 8-bit sample per channel on a flat input vector, so no quantizer is modelled.

The same start line also acts as a sleep control. Its level at the moment a conversion finishes decides whether the block sleeps. In sleep, the next rising edge on that line wakes the block after a programmable power-up delay. An optional active-low power-down input forces sleep directly.

A host reads the last result over an 8-bit tri-state bus gated by chip select and read strobe. The same read access latches the channel address that the next conversion will use. A start request that arrives while the block is busy is dropped and recorded in a sticky error flag.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset, done_n is 1, track_o is 1, asleep_o is 0, err_o is 0, the bus is released, and the result register holds 0x00.
- R2: A falling edge on convst_n while idle starts a conversion. The result appears in the cycle after CONV_CYC rising edges. In that same cycle done_n goes low, and it stays low for EOC_CYC cycles.
- R3: track_o is 0 for exactly TRACK_CYC cycles from the start of a conversion, and is 1 otherwise.
- R4: The result register changes only when a conversion ends. It takes the sample the selected channel held at the start edge, so a read during a conversion returns the previous result and later sample changes have no effect.
- R5: If convst_n is low when a conversion ends, asleep_o goes to 1 together with the done pulse. If convst_n is high at that moment, asleep_o stays 0.
- R6: In sleep, a rising edge on convst_n starts a wake-up. asleep_o stays 1 for PWRUP_CYC cycles after that edge and then drops to 0, after which conversions run normally.
- R7: db is driven only while both cs_n and rd_n are 0. Otherwise it is high impedance.
- R8: A falling edge of rd_n with cs_n low latches the channel address for the next conversion. With NUM_CH of 8, all three address bits are used. With 4, only addr[1:0] is used. With 1, the address is ignored.
- R9: When HAS_PD is 1, pd_n low forces sleep within one cycle. It aborts a running conversion with no done pulse and no result update. When pd_n returns high, the block wakes after PWRUP_CYC cycles. When HAS_PD is 0, pd_n has no effect.
- R10: A falling edge on convst_n during a conversion or during wake-up is ignored, so conversion timing is unchanged. It sets err_o, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_n | input | 1 | Start request (falling edge) and sleep/wake level |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 3 | Channel address for the next conversion |
| pd_n | input | 1 | Active-low forced power-down |
| chan_sample | input | NUM_CH*8 | One 8-bit sample per channel, channel 0 in the low byte |
| db | inout | 8 | Tri-state result bus |
| done_n | output | 1 | Active-low end-of-conversion pulse |
| track_o | output | 1 | 1 while the sample stage is tracking |
| asleep_o | output | 1 | 1 while asleep or waking |
| err_o | output | 1 | Sticky flag for ignored start requests |

## Verification
The bench builds two copies that share one set of stimuli. The first has eight channels, the power-down input enabled, and short timings: 12 conversion cycles, a 4-cycle hold window, a 20-cycle wake-up and a 2-cycle done pulse. The second has four channels and no power-down input. The short timings let sleep, wake-up, aborted conversions and early start requests all fit into a few hundred cycles. The four-channel copy shows address bit 2 being dropped, and it shows pd_n being ignored while its twin aborts.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SLEEP,
        ST_WAKE,
        ST_PDOWN
    } seq_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_evt_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det
    import adc_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_i,
    output edge_evt_t evt_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sig_i;
    end

    always_comb begin
        evt_o.fall = prev_q & ~sig_i;
        evt_o.rise = ~prev_q & sig_i;
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_CYC  = 53,
    parameter int TRACK_CYC = 15,
    parameter int PWRUP_CYC = 125,
    parameter int EOC_CYC   = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t cv_evt,
    input  logic      convst_n,
    input  logic      pd_req,
    output logic      start_o,
    output logic      done_o,
    output logic      done_n,
    output logic      track_o,
    output logic      asleep_o,
    output logic      err_o
);
    localparam int CNT_MAX = max_of(CONV_CYC, PWRUP_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int EOC_W   = $clog2(EOC_CYC + 1);
    localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] PWRUP_LAST = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] TRACK_END  = CNT_W'(TRACK_CYC);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EOC_W-1:0] eoc_q;
    logic             err_q;

    assign start_o  = (state_q == ST_IDLE) && cv_evt.fall && !pd_req;
    assign done_o   = (state_q == ST_CONV) && (cnt_q == CONV_LAST) && !pd_req;
    assign done_n   = (eoc_q == '0);
    assign track_o  = !((state_q == ST_CONV) && (cnt_q < TRACK_END));
    assign asleep_o = (state_q == ST_SLEEP) || (state_q == ST_WAKE) ||
                      (state_q == ST_PDOWN);
    assign err_o    = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            eoc_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (eoc_q != '0) eoc_q <= eoc_q - 1'b1;
            if (pd_req) begin
                state_q <= ST_PDOWN;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_o) begin
                            state_q <= ST_CONV;
                            cnt_q   <= '0;
                        end
                    end
                    ST_CONV: begin
                        if (cv_evt.fall) err_q <= 1'b1;
                        if (done_o) begin
                            eoc_q   <= EOC_W'(EOC_CYC);
                            state_q <= convst_n ? ST_IDLE : ST_SLEEP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_SLEEP: begin
                        if (cv_evt.rise) begin
                            state_q <= ST_WAKE;
                            cnt_q   <= '0;
                        end
                    end
                    ST_WAKE: begin
                        if (cv_evt.fall) err_q <= 1'b1;
                        if (cnt_q == PWRUP_LAST) begin
                            state_q <= ST_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= ST_WAKE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    AST_EOC_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
        $fell(done_n) |-> ($past(state_q) == ST_CONV)); // R2
    AST_SLEEP_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && $past(state_q) == ST_CONV) |-> !$past(convst_n)); // R5
    AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE && $past(state_q) == ST_SLEEP) |-> $past(convst_n)); // R6
    AST_PD_FORCES_SLEEP: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> (state_q == ST_PDOWN)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R10
endmodule

// File: rtl/adc_chan_latch.sv
module adc_chan_latch
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = chan_bits(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch_sel
);
    generate
        if (NUM_CH == 1) begin : g_single
            assign ch_sel = '0;
        end else begin : g_multi
            logic rd_prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rd_prev_q <= 1'b1;
                    ch_sel    <= '0;
                end else begin
                    rd_prev_q <= rd_n;
                    if (rd_prev_q && !rd_n && !cs_n)
                        ch_sel <= addr[CH_W-1:0];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = chan_bits(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     done_i,
    input  logic [CH_W-1:0]          ch_sel,
    input  logic [NUM_CH*DATA_W-1:0] chan_sample,
    input  logic                     cs_n,
    input  logic                     rd_n,
    output logic [DATA_W-1:0]        result_o,
    output logic                     bus_en_o
);
    logic [DATA_W-1:0] chan_arr [NUM_CH];
    logic [DATA_W-1:0] held_q;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
            assign chan_arr[i] = chan_sample[i*DATA_W +: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            result_o <= '0;
        end else begin
            if (start_i) held_q   <= chan_arr[ch_sel];
            if (done_i)  result_o <= held_q;
        end
    end

    assign bus_en_o = !cs_n && !rd_n;
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter bit HAS_PD    = 1'b1,
    parameter int CONV_CYC  = 53,
    parameter int TRACK_CYC = 15,
    parameter int PWRUP_CYC = 125,
    parameter int EOC_CYC   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     convst_n,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     pd_n,
    input  logic [NUM_CH*DATA_W-1:0] chan_sample,
    inout  wire  [DATA_W-1:0]        db,
    output logic                     done_n,
    output logic                     track_o,
    output logic                     asleep_o,
    output logic                     err_o
);
    localparam int CH_W = chan_bits(NUM_CH);

    edge_evt_t         cv_evt;
    logic              pd_req;
    logic              start_w;
    logic              done_w;
    logic [CH_W-1:0]   ch_sel;
    logic [DATA_W-1:0] result;
    logic              bus_en;

    generate
        if (HAS_PD) begin : g_pd
            assign pd_req = !pd_n;
        end else begin : g_no_pd
            assign pd_req = 1'b0;
        end
    endgenerate

    adc_edge_det u_cv_edge (
        .clk(clk), .rst(rst), .sig_i(convst_n), .evt_o(cv_evt)
    );

    adc_conv_seq #(
        .CONV_CYC(CONV_CYC), .TRACK_CYC(TRACK_CYC),
        .PWRUP_CYC(PWRUP_CYC), .EOC_CYC(EOC_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .cv_evt(cv_evt), .convst_n(convst_n),
        .pd_req(pd_req), .start_o(start_w), .done_o(done_w),
        .done_n(done_n), .track_o(track_o), .asleep_o(asleep_o),
        .err_o(err_o)
    );

    adc_chan_latch #(.NUM_CH(NUM_CH)) u_chan (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
        .addr(addr), .ch_sel(ch_sel)
    );

    adc_result_port #(.NUM_CH(NUM_CH)) u_port (
        .clk(clk), .rst(rst), .start_i(start_w), .done_i(done_w),
        .ch_sel(ch_sel), .chan_sample(chan_sample), .cs_n(cs_n),
        .rd_n(rd_n), .result_o(result), .bus_en_o(bus_en)
    );

    assign db = bus_en ? result : {DATA_W{1'bz}};

    AST_RESULT_AT_EOC: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $fell(done_n)); // R4
endmodule

// File: tb/tb_adc_ctrl_top.sv
module tb_adc_ctrl_top;
    localparam int CONV = 12;
    localparam int TRK  = 4;
    localparam int PWR  = 20;
    localparam int EOC  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        convst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        pd_n = 1'b1;
    logic [2:0]  addr = 3'd0;
    logic [63:0] chan_sample;
    logic        tb_en = 1'b0;
    wire  [7:0]  db8;
    wire  [7:0]  db4;
    logic        done8_n, trk8, slp8, err8;
    logic        done4_n, trk4, slp4, err4;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    assign db8 = tb_en ? 8'hA5 : 8'hzz;
    assign db4 = tb_en ? 8'hA5 : 8'hzz;

    adc_ctrl_top #(.NUM_CH(8), .HAS_PD(1'b1), .CONV_CYC(CONV), .TRACK_CYC(TRK),
                   .PWRUP_CYC(PWR), .EOC_CYC(EOC)) dut (
        .clk(clk), .rst(rst), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
        .addr(addr), .pd_n(pd_n), .chan_sample(chan_sample), .db(db8),
        .done_n(done8_n), .track_o(trk8), .asleep_o(slp8), .err_o(err8)
    );

    adc_ctrl_top #(.NUM_CH(4), .HAS_PD(1'b0), .CONV_CYC(CONV), .TRACK_CYC(TRK),
                   .PWRUP_CYC(PWR), .EOC_CYC(EOC)) dut4 (
        .clk(clk), .rst(rst), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
        .addr(addr), .pd_n(pd_n), .chan_sample(chan_sample[31:0]), .db(db4),
        .done_n(done4_n), .track_o(trk4), .asleep_o(slp4), .err_o(err4)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_samples();
        for (int i = 0; i < 8; i++) chan_sample[i*8 +: 8] = 8'h0A + 8'(8'h11 * i);
    endtask

    task automatic do_reset();
        load_samples();
        convst_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; pd_n = 1'b1; tb_en = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v8, output logic [7:0] v4);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        step(1);
        v8 = db8; v4 = db4;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v8, v4;
        do_reset();
        check("R1 done_n", {31'd0, done8_n}, 32'd1);
        check("R1 track_o", {31'd0, trk8}, 32'd1);
        check("R1 asleep_o", {31'd0, slp8}, 32'd0);
        check("R1 err_o", {31'd0, err8}, 32'd0);
        tb_en = 1'b1; step(1);
        check("R1 bus released", {24'd0, db8}, 32'hA5);
        tb_en = 1'b0;
        bus_read(3'd0, v8, v4);
        check("R1 result zero", {24'd0, v8}, 32'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v8, v4;
        do_reset();
        bus_read(3'd6, v8, v4);
        convst_n = 1'b0;
        step(1);  check("R3 hold at step1", {31'd0, trk8}, 32'd0);
        step(1);  convst_n = 1'b1;
        step(2);  check("R3 hold at last cycle", {31'd0, trk8}, 32'd0);
        step(1);  check("R3 tracking again", {31'd0, trk8}, 32'd1);
        step(7);  check("R2 done_n high before end", {31'd0, done8_n}, 32'd1);
        step(1);  check("R2 done_n low at end", {31'd0, done8_n}, 32'd0);
                  check("R5 stays awake with convst high", {31'd0, slp8}, 32'd0);
        step(1);  check("R2 done_n low second cycle", {31'd0, done8_n}, 32'd0);
        step(1);  check("R2 done_n back high", {31'd0, done8_n}, 32'd1);
        check("R10 no error on clean run", {31'd0, err8}, 32'd0);
        bus_read(3'd6, v8, v4);
        check("R2 result channel 6", {24'd0, v8}, 32'h70);
        check("R8 four-channel copy drops bit 2", {24'd0, v4}, 32'h2C);
        tb_en = 1'b1; cs_n = 1'b0; rd_n = 1'b1; step(1);
        check("R7 bus released with rd_n high", {24'd0, db8}, 32'hA5);
        cs_n = 1'b1; rd_n = 1'b0; step(1);
        check("R7 bus released with cs_n high", {24'd0, db8}, 32'hA5);
        rd_n = 1'b1; tb_en = 1'b0; step(1);
    endtask

    task automatic t_hold();
        logic [7:0] v8, v4;
        do_reset();
        bus_read(3'd3, v8, v4);
        convst_n = 1'b0;
        step(1);  chan_sample[3*8 +: 8] = 8'hEE;
        step(1);  convst_n = 1'b1;
        step(3);
        bus_read(3'd3, v8, v4);
        check("R4 read during conversion gives previous", {24'd0, v8}, 32'h00);
        step(8);  check("R2 done_n low in hold test", {31'd0, done8_n}, 32'd0);
        bus_read(3'd3, v8, v4);
        check("R4 held sample used", {24'd0, v8}, 32'h3D);
        check("R4 held sample used in 4ch copy", {24'd0, v4}, 32'h3D);
    endtask

    task automatic t_sleep();
        logic [7:0] v8, v4;
        do_reset();
        convst_n = 1'b0;
        step(12); check("R5 awake before end", {31'd0, slp8}, 32'd0);
        step(1);  check("R5 asleep with done pulse", {31'd0, slp8}, 32'd1);
                  check("R5 done pulse on sleep entry", {31'd0, done8_n}, 32'd0);
        step(5);  check("R5 remains asleep", {31'd0, slp8}, 32'd1);
        convst_n = 1'b1;
        step(1);  check("R6 waking", {31'd0, slp8}, 32'd1);
        step(PWR - 1); check("R6 still waking at last cycle", {31'd0, slp8}, 32'd1);
        step(1);  check("R6 awake after delay", {31'd0, slp8}, 32'd0);
        check("R10 no error from wake", {31'd0, err8}, 32'd0);
        bus_read(3'd1, v8, v4);
        convst_n = 1'b0;
        step(2);  convst_n = 1'b1;
        step(11); check("R6 conversion after wake", {31'd0, done8_n}, 32'd0);
        bus_read(3'd1, v8, v4);
        check("R6 result after wake", {24'd0, v8}, 32'h1B);
    endtask

    task automatic t_pd();
        logic [7:0] v8, v4;
        bit eoc_seen8, eoc_seen4;
        do_reset();
        bus_read(3'd5, v8, v4);
        convst_n = 1'b0;
        step(2);  convst_n = 1'b1;
        step(3);  pd_n = 1'b0;
        step(1);  check("R9 forced sleep", {31'd0, slp8}, 32'd1);
                  check("R9 no effect without pd", {31'd0, slp4}, 32'd0);
        eoc_seen8 = 1'b0; eoc_seen4 = 1'b0;
        for (int k = 7; k <= 16; k++) begin
            step(1);
            if (!done8_n) eoc_seen8 = 1'b1;
            if (!done4_n) eoc_seen4 = 1'b1;
        end
        check("R9 aborted conversion has no done pulse", {31'd0, eoc_seen8}, 32'd0);
        check("R9 four-channel copy completes", {31'd0, eoc_seen4}, 32'd1);
        pd_n = 1'b1;
        step(1);  check("R9 waking after release", {31'd0, slp8}, 32'd1);
        step(PWR); check("R9 awake after delay", {31'd0, slp8}, 32'd0);
        bus_read(3'd5, v8, v4);
        check("R9 result not updated", {24'd0, v8}, 32'h00);
        check("R9 four-channel result", {24'd0, v4}, 32'h1B);
    endtask

    task automatic t_err();
        do_reset();
        convst_n = 1'b0;
        step(2);  convst_n = 1'b1;
        step(2);  convst_n = 1'b0;
        step(2);  convst_n = 1'b1;
        step(1);  check("R10 error set by early start", {31'd0, err8}, 32'd1);
        step(5);  check("R10 original timing kept", {31'd0, done8_n}, 32'd1);
        step(1);  check("R10 done at original time", {31'd0, done8_n}, 32'd0);
        step(7);  check("R10 error sticky", {31'd0, err8}, 32'd1);
        do_reset();
        convst_n = 1'b0;
        step(14); convst_n = 1'b1;
        step(3);  convst_n = 1'b0;
        step(2);  check("R10 error set during wake", {31'd0, err8}, 32'd1);
                  check("R10 still waking", {31'd0, slp8}, 32'd1);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        load_samples();
        step(1);
        t_reset();
        t_basic();
        t_hold();
        t_sleep();
        t_pd();
        t_err();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule